// File: doc/BRIEF.md
# Power Partition Gating Sequencer

This block keeps the power state of a set of independent power partitions. A status vector holds one bit per partition, and a 1 means the partition is powered. Software changes that state in three ways. It can write a toggle word that flips one partition. It can raise a level request that asks for on or off and takes effect only when the current state differs. It can write a clamp-removal word that releases the isolation clamps of a partition. Every index is checked against the configured partition count. A request with an out-of-range index raises a one-cycle error flag and changes nothing.

A hardware sequencer brings one partition up in a fixed order: reset asserted, power on, clock enabled, a settle wait, clamps removed, a second settle wait, reset released. Each settle wait is `CLK_MHZ * SETTLE_US` cycles long. A fault reported while the clock is being enabled, or while the clamps are being removed, makes the sequencer undo the steps already taken in reverse order. The partition reset stays asserted after such a fault. The partition count may be 0, 7, 14, 23 or 25, and a count of 0 makes every request fail.

Top module: `pwr_gate_seq`

## Requirements
- R1: After reset, every bit of pwrStatus, clampOff, partClkEn and partRst is 0, and errFlag, busy, seqDone and seqFail are all 0.
- R2: A write with regSel=0 whose bit 8 is 1 flips pwrStatus[regWdata[4:0]] one cycle later when that index is below NUM_PART. A write with bit 8 at 0 has no effect and raises no error.
- R3: A level request (reqValid, with reqOn giving the target state) sets the partition to the requested state. When the partition is already in that state, pwrStatus does not change.
- R4: An index is out of range when a 6-bit two's-complement index (reqIdx, seqIdx) is negative, or when any index is not below NUM_PART. An out-of-range index on a toggle write, a clamp write, a level request or a sequencer start raises errFlag for exactly one cycle and leaves pwrStatus, clampOff and busy unchanged.
- R5: A write with regSel=1 carries the index in regWdata[4:0] and sets the clampOff bit of the mapped partition one cycle later. Index VDEC_ID (default 2) maps to bit PCIE_ID (default 3), index PCIE_ID maps to bit VDEC_ID, and every other index maps to its own bit.
- R6: A clampOff bit is never 1 while its partition is unpowered. Powering a partition off clears its clampOff bit, and a clamp removal aimed at an unpowered partition has no effect.
- R7: A valid seqStart sampled at edge e0 makes partRst of the partition visible after e1, its power after e2 and partClkEn after e3. The clamp is released W+1 cycles after the clock, and the reset is released W+1 cycles after the clamp, where W = CLK_MHZ*SETTLE_US. seqDone pulses for one cycle together with the reset release.
- R8: When clkFail is high in the clock step, partClkEn is never set and the partition is powered off two cycles after its power came on. seqFail pulses in that same cycle and partRst stays asserted.
- R9: When clampFail is high in the clamp step, the clamp stays engaged. partClkEn is cleared one cycle after the clamp would have been released, and the partition is powered off one cycle after that. seqFail pulses with the power-off and partRst stays asserted.
- R10: busy is high from the cycle after a valid start until the cycle of seqDone or seqFail. While busy is high, regWr, reqValid and seqStart are ignored and raise no error.
- R11: When no sequence is running, regWr takes priority over reqValid, and reqValid takes priority over seqStart. An input that loses in the same cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regSel | input | 1 | 0 selects the toggle word, 1 selects the clamp-removal word |
| regWdata | input | 16 | Write data: bit 8 is start (toggle only), bits [4:0] are the index |
| reqValid | input | 1 | Level request strobe |
| reqOn | input | 1 | Requested state: 1 for on, 0 for off |
| reqIdx | input | 6 | Level request index, two's complement |
| seqStart | input | 1 | Starts the power-up sequencer |
| seqIdx | input | 6 | Sequencer partition index, two's complement |
| clkFail | input | 1 | Clock-enable step fault |
| clampFail | input | 1 | Clamp-removal step fault |
| pwrStatus | output | PW | Power state, one bit per partition |
| clampOff | output | PW | Clamps released, one bit per partition |
| partClkEn | output | PW | Partition clock enables |
| partRst | output | PW | Partition resets, active high |
| errFlag | output | 1 | One-cycle error flag for a rejected request |
| busy | output | 1 | Sequencer running |
| seqDone | output | 1 | One-cycle pulse when a sequence succeeds |
| seqFail | output | 1 | One-cycle pulse when an unwind ends |

## Verification
Register writes and level requests are due one cycle after the edge that samples them. The bench drives each request on a falling edge, removes it on the next falling edge, and compares the outputs and errFlag at that second falling edge. For sequences, the bench keeps a falling-edge cycle count from the start and records the first cycle in which each output of the chosen partition changes. It then compares those cycle numbers with the offsets derived in R7 to R9: 2, 3 and 4 for reset, power and clock, W+5 and 2W+6 for a successful run, and W+6 and W+7 for a clamp-fault unwind.

// File: rtl/ppg_pkg.sv
package ppg_pkg;

  // Strobes sent from control to datapath; at most one source per cycle
  typedef struct packed {
    logic       tgl;
    logic       setOn;
    logic       setOff;
    logic       clampRm;
    logic       rstSet;
    logic       rstClr;
    logic       clkOn;
    logic       clkOff;
    logic       err;
    logic [4:0] idx;
  } ppg_strobe_t;

  typedef enum logic [3:0] {
    S_IDLE, S_RST, S_PWR, S_CLK, S_W1, S_CLAMP, S_W2, S_REL, S_UNCLK, S_UNPWR
  } ppg_state_t;

  localparam int START_BIT = 8;

endpackage

// File: rtl/ppg_ctrl.sv
module ppg_ctrl
  import ppg_pkg::*;
#(
  parameter int NUM_PART = 7,
  parameter int WAIT_CYC = 1250
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWr,
  input  logic        regSel,
  input  logic [15:0] regWdata,
  input  logic        reqValid,
  input  logic        reqOn,
  input  logic [5:0]  reqIdx,
  input  logic        seqStart,
  input  logic [5:0]  seqIdx,
  input  logic        clkFail,
  input  logic        clampFail,
  output ppg_strobe_t stb,
  output logic        busy,
  output logic        seqDone,
  output logic        seqFail
);

  localparam int CW = $clog2(WAIT_CYC + 1);

  ppg_state_t      st, nxt;
  logic [CW-1:0]   cnt, cntNxt;
  logic [4:0]      sIdx;

  function automatic logic fieldOk(input logic [4:0] f);
    return int'(f) < NUM_PART;
  endfunction

  function automatic logic signedOk(input logic [5:0] v);
    return !v[5] && fieldOk(v[4:0]);
  endfunction

  always_comb begin
    stb    = '0;
    nxt    = st;
    cntNxt = cnt;
    if (st != S_IDLE) stb.idx = sIdx;
    case (st)
      S_IDLE: begin
        if (regWr) begin
          stb.idx = regWdata[4:0];
          if (regSel) begin
            if (fieldOk(regWdata[4:0])) stb.clampRm = 1'b1;
            else                        stb.err     = 1'b1;
          end else if (regWdata[START_BIT]) begin
            if (fieldOk(regWdata[4:0])) stb.tgl = 1'b1;
            else                        stb.err = 1'b1;
          end
        end else if (reqValid) begin
          stb.idx = reqIdx[4:0];
          if (signedOk(reqIdx)) begin
            stb.setOn  = reqOn;
            stb.setOff = !reqOn;
          end else begin
            stb.err = 1'b1;
          end
        end else if (seqStart) begin
          if (signedOk(seqIdx)) nxt = S_RST;
          else                  stb.err = 1'b1;
        end
      end
      S_RST:   begin stb.rstSet = 1'b1; nxt = S_PWR; end
      S_PWR:   begin stb.setOn  = 1'b1; nxt = S_CLK; end
      S_CLK: begin
        if (clkFail) nxt = S_UNPWR;
        else begin
          stb.clkOn = 1'b1;
          cntNxt    = CW'(WAIT_CYC - 1);
          nxt       = S_W1;
        end
      end
      S_W1: begin
        if (cnt == '0) nxt = S_CLAMP;
        else           cntNxt = cnt - 1'b1;
      end
      S_CLAMP: begin
        if (clampFail) nxt = S_UNCLK;
        else begin
          stb.clampRm = 1'b1;
          cntNxt      = CW'(WAIT_CYC - 1);
          nxt         = S_W2;
        end
      end
      S_W2: begin
        if (cnt == '0) nxt = S_REL;
        else           cntNxt = cnt - 1'b1;
      end
      S_REL:   begin stb.rstClr = 1'b1; nxt = S_IDLE; end
      S_UNCLK: begin stb.clkOff = 1'b1; nxt = S_UNPWR; end
      S_UNPWR: begin stb.setOff = 1'b1; nxt = S_IDLE; end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st      <= S_IDLE;
      cnt     <= '0;
      sIdx    <= '0;
      seqDone <= 1'b0;
      seqFail <= 1'b0;
    end else begin
      st      <= nxt;
      cnt     <= cntNxt;
      if (st == S_IDLE) sIdx <= seqIdx[4:0];
      seqDone <= (st == S_REL);
      seqFail <= (st == S_UNPWR);
    end
  end

  assign busy = (st != S_IDLE);

  // R7: settle wait is not cut short
  p_wait_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (st == S_W1 && cnt != '0) |=> (st == S_W1));

  // R8: clock fault skips straight to power-off
  p_clk_unwind_r8: assert property (@(posedge clk) disable iff (!rstN)
    (st == S_CLK && clkFail) |=> (st == S_UNPWR));

  // R9: clamp fault disables the clock first
  p_clamp_unwind_r9: assert property (@(posedge clk) disable iff (!rstN)
    (st == S_CLAMP && clampFail) |=> (st == S_UNCLK));

  // R10: no request strobe from the ports while a sequence runs
  p_busy_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    (st != S_IDLE) |-> !(stb.tgl || stb.err));

endmodule

// File: rtl/ppg_dp.sv
module ppg_dp
  import ppg_pkg::*;
#(
  parameter int NUM_PART = 7,
  parameter int VDEC_ID  = 2,
  parameter int PCIE_ID  = 3,
  localparam int PW      = (NUM_PART > 0) ? NUM_PART : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  ppg_strobe_t   stb,
  output logic [PW-1:0] pwrStatus,
  output logic [PW-1:0] clampOff,
  output logic [PW-1:0] partClkEn,
  output logic [PW-1:0] partRst,
  output logic          errFlag
);

  localparam logic [4:0] VD = 5'(VDEC_ID);
  localparam logic [4:0] PC = 5'(PCIE_ID);

  logic [4:0] clampIdx;

  always_comb begin
    if      (stb.idx == VD) clampIdx = PC;
    else if (stb.idx == PC) clampIdx = VD;
    else                    clampIdx = stb.idx;
  end

  for (genvar i = 0; i < PW; i++) begin : g_part
    logic pQ, cQ, kQ, rQ, hit, pNext;

    assign hit = (stb.idx == 5'(i));

    always_comb begin
      pNext = pQ;
      if (hit && stb.tgl)         pNext = !pQ;
      else if (hit && stb.setOn)  pNext = 1'b1;
      else if (hit && stb.setOff) pNext = 1'b0;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        pQ <= 1'b0;
        cQ <= 1'b0;
        kQ <= 1'b0;
        rQ <= 1'b0;
      end else begin
        pQ <= pNext;
        cQ <= pNext && (cQ || (stb.clampRm && clampIdx == 5'(i)));
        if (hit && stb.clkOn)       kQ <= 1'b1;
        else if (hit && stb.clkOff) kQ <= 1'b0;
        if (hit && stb.rstSet)      rQ <= 1'b1;
        else if (hit && stb.rstClr) rQ <= 1'b0;
      end
    end

    assign pwrStatus[i] = pQ;
    assign clampOff[i]  = cQ;
    assign partClkEn[i] = kQ;
    assign partRst[i]   = rQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) errFlag <= 1'b0;
    else       errFlag <= stb.err;
  end

  // R2: at most one partition changes power state per cycle
  p_one_flip_r2: assert property (@(posedge clk) disable iff (!rstN)
    $countones(pwrStatus ^ $past(pwrStatus)) <= 1);

  // R4: a rejected request leaves the state alone
  p_err_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> (pwrStatus == $past(pwrStatus) && clampOff == $past(clampOff)));

  // R6: released clamps only on powered partitions
  p_clamp_pwr_r6: assert property (@(posedge clk) disable iff (!rstN)
    (clampOff & ~pwrStatus) == '0);

endmodule

// File: rtl/pwr_gate_seq.sv
module pwr_gate_seq
  import ppg_pkg::*;
#(
  parameter int NUM_PART  = 7,
  parameter int CLK_MHZ   = 125,
  parameter int SETTLE_US = 10,
  parameter int VDEC_ID   = 2,
  parameter int PCIE_ID   = 3,
  localparam int PW       = (NUM_PART > 0) ? NUM_PART : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWr,
  input  logic          regSel,
  input  logic [15:0]   regWdata,
  input  logic          reqValid,
  input  logic          reqOn,
  input  logic [5:0]    reqIdx,
  input  logic          seqStart,
  input  logic [5:0]    seqIdx,
  input  logic          clkFail,
  input  logic          clampFail,
  output logic [PW-1:0] pwrStatus,
  output logic [PW-1:0] clampOff,
  output logic [PW-1:0] partClkEn,
  output logic [PW-1:0] partRst,
  output logic          errFlag,
  output logic          busy,
  output logic          seqDone,
  output logic          seqFail
);

  localparam int WAIT_CYC = CLK_MHZ * SETTLE_US;

  ppg_strobe_t stb;

  ppg_ctrl #(.NUM_PART(NUM_PART), .WAIT_CYC(WAIT_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regSel(regSel), .regWdata(regWdata),
    .reqValid(reqValid), .reqOn(reqOn), .reqIdx(reqIdx),
    .seqStart(seqStart), .seqIdx(seqIdx), .clkFail(clkFail), .clampFail(clampFail),
    .stb(stb), .busy(busy), .seqDone(seqDone), .seqFail(seqFail)
  );

  ppg_dp #(.NUM_PART(NUM_PART), .VDEC_ID(VDEC_ID), .PCIE_ID(PCIE_ID)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .pwrStatus(pwrStatus), .clampOff(clampOff), .partClkEn(partClkEn),
    .partRst(partRst), .errFlag(errFlag)
  );

endmodule

// File: tb/sim_pwr_gate_seq.sv
module sim_pwr_gate_seq;

  localparam int N = 7;
  localparam int W = 125 * 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWr = 1'b0, regSel = 1'b0, reqValid = 1'b0, reqOn = 1'b0;
  logic seqStart = 1'b0, clkFail = 1'b0, clampFail = 1'b0;
  logic [15:0] regWdata = '0;
  logic [5:0] reqIdx = '0, seqIdx = '0;
  logic [N-1:0] pwrStatus, clampOff, partClkEn, partRst;
  logic errFlag, busy, seqDone, seqFail;

  int nChk = 0, nFail = 0, cyc = 0;
  logic [N-1:0] mPwr = '0, mClamp = '0;
  int tRst, tPwr, tPwrOff, tClk, tClkOff, tClamp, tRel, tDone, tFail, tBusy;

  always #4 clk = !clk;

  pwr_gate_seq #(.NUM_PART(N)) u0 (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regSel(regSel), .regWdata(regWdata),
    .reqValid(reqValid), .reqOn(reqOn), .reqIdx(reqIdx),
    .seqStart(seqStart), .seqIdx(seqIdx), .clkFail(clkFail), .clampFail(clampFail),
    .pwrStatus(pwrStatus), .clampOff(clampOff), .partClkEn(partClkEn),
    .partRst(partRst), .errFlag(errFlag), .busy(busy), .seqDone(seqDone), .seqFail(seqFail)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int mapC(input int i);
    if (i == 2) return 3;
    if (i == 3) return 2;
    return i;
  endfunction

  task automatic settle(input string req, input logic expErr);
    check({req, " pwr"}, 32'(pwrStatus), 32'(mPwr));
    check({req, " clamp"}, 32'(clampOff), 32'(mClamp));
    check({req, " err"}, 32'(errFlag), 32'(expErr));
  endtask

  task automatic regWrite(input logic sel, input logic [15:0] d);
    @(negedge clk); regWr = 1'b1; regSel = sel; regWdata = d;
    @(negedge clk); regWr = 1'b0;
  endtask

  task automatic levelReq(input logic on, input logic [5:0] idx);
    @(negedge clk); reqValid = 1'b1; reqOn = on; reqIdx = idx;
    @(negedge clk); reqValid = 1'b0;
  endtask

  // apply the model for a valid power transition
  task automatic modelSet(input int i, input logic v);
    mPwr[i] = v;
    if (!v) mClamp[i] = 1'b0;
  endtask

  task automatic runSeq(input int idx, input logic cf, input logic mf, input logic intrude);
    int t;
    tRst = -1; tPwr = -1; tPwrOff = -1; tClk = -1; tClkOff = -1;
    tClamp = -1; tRel = -1; tDone = -1; tFail = -1; tBusy = -1;
    clkFail = cf; clampFail = mf;
    @(negedge clk); seqStart = 1'b1; seqIdx = 6'(idx);
    t = 0;
    while (tDone < 0 && tFail < 0 && t < 6000) begin
      @(negedge clk); t++;
      if (t == 1) seqStart = 1'b0;
      if (intrude && t == 10) begin
        regWr = 1'b1; regSel = 1'b0; regWdata = 16'h0100;
        reqValid = 1'b1; reqOn = 1'b0; reqIdx = 6'd1;
        seqStart = 1'b1; seqIdx = 6'd0;
      end
      if (intrude && t == 11) begin
        check("R10 no err while busy", 32'(errFlag), 0);
        regWr = 1'b0; reqValid = 1'b0; seqStart = 1'b0;
      end
      if (tBusy < 0 && busy) tBusy = t;
      if (tRst < 0 && partRst[idx]) tRst = t;
      if (tRst >= 0 && tRel < 0 && !partRst[idx]) tRel = t;
      if (tPwr < 0 && pwrStatus[idx]) tPwr = t;
      if (tPwr >= 0 && tPwrOff < 0 && !pwrStatus[idx]) tPwrOff = t;
      if (tClk < 0 && partClkEn[idx]) tClk = t;
      if (tClk >= 0 && tClkOff < 0 && !partClkEn[idx]) tClkOff = t;
      if (tClamp < 0 && clampOff[idx]) tClamp = t;
      if (seqDone) tDone = t;
      if (seqFail) tFail = t;
    end
    clkFail = 1'b0; clampFail = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 pwr", 32'(pwrStatus), 0);
    check("R1 clamp", 32'(clampOff), 0);
    check("R1 clk", 32'(partClkEn), 0);
    check("R1 rst", 32'(partRst), 0);
    check("R1 flags", {28'd0, errFlag, busy, seqDone, seqFail}, 0);

    // R2/R4 toggle sweep over every field value
    for (int i = 0; i < 32; i++) begin
      regWrite(1'b0, 16'h0100 | 16'(i));
      if (i < N) modelSet(i, !mPwr[i]);
      settle("R2 toggle / R4 range", i >= N);
    end
    regWrite(1'b0, 16'h0001);
    settle("R2 start clear no effect", 1'b0);

    // R3/R4 level request sweep over every signed index, twice
    for (int pass = 0; pass < 2; pass++) begin
      for (int v = -32; v < 32; v++) begin
        logic on;
        on = ((v + pass) % 3) != 0;
        levelReq(on, 6'(v));
        if (v >= 0 && v < N) modelSet(v, on);
        settle("R3 level / R4 range", v < 0 || v >= N);
      end
    end

    // R5/R6 clamp sweep: all on except partition 5
    for (int i = 0; i < N; i++) begin
      levelReq(i != 5, 6'(i));
      modelSet(i, i != 5);
    end
    for (int i = 0; i < 32; i++) begin
      regWrite(1'b1, 16'(i));
      if (i < N && mPwr[mapC(i)]) mClamp[mapC(i)] = 1'b1;
      settle("R5 clamp map / R4 range / R6", i >= N);
    end
    check("R5 swapped bits set", 32'(clampOff[3:2]), 3);
    check("R6 unpowered clamp stays", 32'(clampOff[5]), 0);
    regWrite(1'b0, 16'h0102);
    modelSet(2, 1'b0);
    settle("R6 power off clears clamp", 1'b0);

    // R11 same-cycle priority
    @(negedge clk);
    regWr = 1'b1; regSel = 1'b0; regWdata = 16'h0101;
    reqValid = 1'b1; reqOn = 1'b1; reqIdx = 6'd2;
    @(negedge clk);
    regWr = 1'b0; reqValid = 1'b0;
    modelSet(1, !mPwr[1]);
    settle("R11 write beats request", 1'b0);

    @(negedge clk);
    reqValid = 1'b1; reqOn = 1'b1; reqIdx = 6'd2;
    seqStart = 1'b1; seqIdx = 6'd4;
    @(negedge clk);
    reqValid = 1'b0; seqStart = 1'b0;
    modelSet(2, 1'b1);
    settle("R11 request beats start", 1'b0);
    check("R11 start dropped", 32'(busy), 0);

    // R4 invalid sequencer starts
    for (int k = 0; k < 2; k++) begin
      @(negedge clk); seqStart = 1'b1; seqIdx = (k == 0) ? 6'h3F : 6'd7;
      @(negedge clk); seqStart = 1'b0;
      settle("R4 bad start", 1'b1);
      check("R4 bad start busy", 32'(busy), 0);
    end

    // R7/R10 successful run on partition 4
    levelReq(1'b0, 6'd4);
    modelSet(4, 1'b0);
    runSeq(4, 1'b0, 1'b0, 1'b1);
    check("R10 busy rise", tBusy, 1);
    check("R7 reset step", tRst, 2);
    check("R7 power step", tPwr, 3);
    check("R7 clock step", tClk, 4);
    check("R7 clamp step", tClamp, W + 5);
    check("R7 release step", tRel, 2 * W + 6);
    check("R7 done pulse", tDone, 2 * W + 6);
    check("R10 busy fall", 32'(busy), 0);
    modelSet(4, 1'b1); mClamp[4] = 1'b1;
    settle("R10 intrusions ignored", 1'b0);
    @(negedge clk);
    check("R7 done one cycle", 32'(seqDone), 0);
    check("R7 clock stays", 32'(partClkEn), 32'h10);

    // R8 clock fault on partition 5 (off)
    runSeq(5, 1'b1, 1'b0, 1'b0);
    check("R8 power step", tPwr, 3);
    check("R8 power off", tPwrOff, 5);
    check("R8 fail pulse", tFail, 5);
    check("R8 clock never", tClk, -1);
    check("R8 reset held", 32'(partRst[5]), 1);
    settle("R8 state", 1'b0);

    // R9 clamp fault on partition 6 (on, clamp engaged)
    levelReq(1'b0, 6'd6); modelSet(6, 1'b0);
    levelReq(1'b1, 6'd6); modelSet(6, 1'b1);
    runSeq(6, 1'b0, 1'b1, 1'b0);
    check("R9 clock step", tClk, 4);
    check("R9 clock off", tClkOff, W + 6);
    check("R9 power off", tPwrOff, W + 7);
    check("R9 fail pulse", tFail, W + 7);
    check("R9 clamp never", tClamp, -1);
    check("R9 reset held", 32'(partRst[6]), 1);
    modelSet(6, 1'b0);
    settle("R9 state", 1'b0);

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nChk++; nFail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

endmodule